// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the device side of a legacy index/data configuration interface on a byte-wide I/O bus. The host reaches configuration registers indirectly. It first writes a register number to the index port, at I/O address 0x2E, and then reads or writes the register's contents through the data port, at 0x2F. The register space stays closed until the host writes a fixed four-byte key to the index port. The host closes it again with a dedicated exit write.

Once the space is open, the host can identify the device from a read-only 16-bit chip identifier and a 4-bit revision. It selects a logical device through a selector register. When the GPIO logical device (number 7) is selected, the host can program that device's 16-bit I/O base address. The block drives the base address out on `gpioBase` so that the GPIO block can decode its own I/O window. The read path is combinational: read data belongs to the cycle in which `ioRdEn` is high.

Top module: `sioCfgPort`

## Requirements
- R1: After reset the port is locked (`cfgActive` = 0), `gpioBase` is 0x0000, and the device selector (register 0x07) reads back 0x00 once the port is unlocked.
- R2: Four consecutive writes to the index port (0x2E) with the bytes 0x87, 0x01, 0x55, 0x55 unlock the port. `cfgActive` goes high on the clock edge that captures the fourth write, and not earlier.
- R3: Any wrong byte written to the index port during the key restarts the match. A wrong byte equal to 0x87 counts as the first key byte. Writes and reads at other addresses do not disturb the match.
- R4: While the port is locked, reads of 0x2E or 0x2F return 0xFF. Writes to 0x2F are ignored, and writes to 0x2E do not load the index.
- R5: While the port is unlocked, writing 0x02 to register 0x02 through the data port relocks it on the next edge. Any other value written to register 0x02 has no effect. Register 0x02 reads as 0x00. The selector and the base address keep their values across relock.
- R6: Register 0x07 is the logical device selector. It is readable and writable over its full 8 bits.
- R7: Register 0x20 returns the high byte of the chip identifier and register 0x21 returns the low byte. Register 0x22 returns the revision in bits 3:0, with bits 7:4 zero. Writes to these registers are ignored.
- R8: When the selector equals 7, registers 0x62 and 0x63 hold the high and low bytes of the GPIO base address, and `gpioBase` follows them. For any other selector value these registers read 0xFF and ignore writes.
- R9: While the port is unlocked, a read of 0x2E returns the current index. Any data-port read of an index not named in R5 to R8 returns 0xFF.
- R10: `ioRdData` is 0x00 when neither port is being read. A read in the same cycle as a write returns the state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address of the current access |
| ioWrEn | input | 1 | Byte write strobe, one cycle per write |
| ioWrData | input | 8 | Write data |
| ioRdEn | input | 1 | Byte read strobe |
| ioRdData | output | 8 | Read data, valid in the cycle of ioRdEn |
| cfgActive | output | 1 | High while the configuration space is unlocked |
| gpioBase | output | 16 | GPIO logical device I/O base address |

## Verification
A read and a write can be presented in the same cycle, and the read must see the state from before the write. This case is provoked in two ways. The first drives a data-port write and a data-port read together to the selector register. The read must return the old selector, and a later read must return the new one. The second relocks the port with the exit write while the same cycle reads register 0x02. The read must give the unlocked value 0x00 rather than the locked 0xFF, and `cfgActive` must fall on the following edge.

// File: rtl/sioCfgPkg.sv
package sioCfgPkg;

  localparam int BYTE_W  = 8;
  localparam int KEY_LEN = 4;

  typedef logic [BYTE_W-1:0] byte_t;

  // register numbers inside the configuration space
  localparam byte_t REG_EXIT    = 8'h02;
  localparam byte_t REG_DEVSEL  = 8'h07;
  localparam byte_t REG_ID_HI   = 8'h20;
  localparam byte_t REG_ID_LO   = 8'h21;
  localparam byte_t REG_REV     = 8'h22;
  localparam byte_t REG_BASE_HI = 8'h62;
  localparam byte_t REG_BASE_LO = 8'h63;

  localparam byte_t EXIT_CODE  = 8'h02;
  localparam byte_t FILL_BYTE  = 8'hFF;
  localparam byte_t IDLE_BYTE  = 8'h00;

  // unlock key, in write order
  function automatic byte_t keyByte(input int pos);
    case (pos)
      0:       keyByte = 8'h87;
      1:       keyByte = 8'h01;
      2:       keyByte = 8'h55;
      default: keyByte = 8'h55;
    endcase
  endfunction

  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_LOCKED = 2'd1,
    RD_INDEX  = 2'd2,
    RD_DATA   = 2'd3
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   idxLoad;
    logic   dataStore;
    rdSel_e rdSel;
  } cfgStrobe_t;

endpackage

// File: rtl/sioCfgCtrl.sv
module sioCfgCtrl
  import sioCfgPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h002E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  byte_t             ioWrData,
  input  logic              ioRdEn,
  input  byte_t             curIndex,
  output cfgStrobe_t        strobe,
  output logic              cfgActive
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = INDEX_ADDR + ADDR_W'(1);
  localparam int POS_W = $clog2(KEY_LEN);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(KEY_LEN - 1);

  logic [POS_W-1:0] keyPos;
  logic             unlockedQ;

  logic hitIdx, hitData;
  logic idxWr, dataWr;
  logic keyStep, keyMatch, keyRestart, exitHit;

  always_comb begin
    hitIdx     = (ioAddr == INDEX_ADDR);
    hitData    = (ioAddr == DATA_ADDR);
    idxWr      = ioWrEn && hitIdx;
    dataWr     = ioWrEn && hitData;
    keyStep    = !unlockedQ && idxWr;
    keyMatch   = (ioWrData == keyByte(int'(keyPos)));
    keyRestart = (ioWrData == keyByte(0));
    exitHit    = unlockedQ && dataWr && (curIndex == REG_EXIT) && (ioWrData == EXIT_CODE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyPos    <= '0;
      unlockedQ <= 1'b0;
    end else if (keyStep) begin
      if (keyMatch) begin
        if (keyPos == LAST_POS) begin
          keyPos    <= '0;
          unlockedQ <= 1'b1;
        end else begin
          keyPos <= keyPos + POS_W'(1);
        end
      end else begin
        keyPos <= keyRestart ? POS_W'(1) : '0;
      end
    end else if (exitHit) begin
      unlockedQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.idxLoad   = unlockedQ && idxWr;
    strobe.dataStore = unlockedQ && dataWr;
    if (ioRdEn && (hitIdx || hitData)) begin
      if (!unlockedQ)  strobe.rdSel = RD_LOCKED;
      else if (hitIdx) strobe.rdSel = RD_INDEX;
      else             strobe.rdSel = RD_DATA;
    end else begin
      strobe.rdSel = RD_IDLE;
    end
  end

  assign cfgActive = unlockedQ;

endmodule

// File: rtl/sioCfgRegs.sv
module sioCfgRegs
  import sioCfgPkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h8728,
  parameter logic [3:0]  CHIP_REV = 4'h6,
  parameter byte_t       GPIO_DEV = 8'h07
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfgStrobe_t  strobe,
  input  byte_t       ioWrData,
  output byte_t       curIndex,
  output byte_t       ioRdData,
  output logic [15:0] gpioBase
);

  byte_t       indexQ;
  byte_t       devSelQ;
  logic [15:0] baseQ;
  logic        gpioSel;
  byte_t       regRead;

  assign gpioSel = (devSelQ == GPIO_DEV);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexQ  <= '0;
      devSelQ <= '0;
      baseQ   <= '0;
    end else begin
      if (strobe.idxLoad) indexQ <= ioWrData;
      if (strobe.dataStore) begin
        case (indexQ)
          REG_DEVSEL:  devSelQ <= ioWrData;
          REG_BASE_HI: if (gpioSel) baseQ[15:8] <= ioWrData;
          REG_BASE_LO: if (gpioSel) baseQ[7:0]  <= ioWrData;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (indexQ)
      REG_EXIT:    regRead = IDLE_BYTE;
      REG_DEVSEL:  regRead = devSelQ;
      REG_ID_HI:   regRead = CHIP_ID[15:8];
      REG_ID_LO:   regRead = CHIP_ID[7:0];
      REG_REV:     regRead = {4'h0, CHIP_REV};
      REG_BASE_HI: regRead = gpioSel ? baseQ[15:8] : FILL_BYTE;
      REG_BASE_LO: regRead = gpioSel ? baseQ[7:0]  : FILL_BYTE;
      default:     regRead = FILL_BYTE;
    endcase
  end

  always_comb begin
    case (strobe.rdSel)
      RD_LOCKED: ioRdData = FILL_BYTE;
      RD_INDEX:  ioRdData = indexQ;
      RD_DATA:   ioRdData = regRead;
      default:   ioRdData = IDLE_BYTE;
    endcase
  end

  assign curIndex = indexQ;
  assign gpioBase = baseQ;

endmodule

// File: rtl/sioCfgPort.sv
module sioCfgPort
  import sioCfgPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h002E,
  parameter logic [15:0] CHIP_ID  = 16'h8728,
  parameter logic [3:0]  CHIP_REV = 4'h6,
  parameter logic [7:0]  GPIO_DEV = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic [7:0]        ioWrData,
  input  logic              ioRdEn,
  output logic [7:0]        ioRdData,
  output logic              cfgActive,
  output logic [15:0]       gpioBase
);

  cfgStrobe_t strobe;
  byte_t      curIndex;

  sioCfgCtrl #(
    .ADDR_W     (ADDR_W),
    .INDEX_ADDR (INDEX_ADDR)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .ioAddr    (ioAddr),
    .ioWrEn    (ioWrEn),
    .ioWrData  (ioWrData),
    .ioRdEn    (ioRdEn),
    .curIndex  (curIndex),
    .strobe    (strobe),
    .cfgActive (cfgActive)
  );

  sioCfgRegs #(
    .CHIP_ID  (CHIP_ID),
    .CHIP_REV (CHIP_REV),
    .GPIO_DEV (GPIO_DEV)
  ) regs_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .ioWrData (ioWrData),
    .curIndex (curIndex),
    .ioRdData (ioRdData),
    .gpioBase (gpioBase)
  );

endmodule

// File: rtl/sioCfgPortChk.sv
module sioCfgPortChk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h002E,
  parameter logic [15:0] CHIP_ID = 16'h8728
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWrEn,
  input logic [7:0]        ioWrData,
  input logic              ioRdEn,
  input logic [7:0]        ioRdData,
  input logic              cfgActive,
  input logic [15:0]       gpioBase,
  input logic [7:0]        curIndex
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = INDEX_ADDR + ADDR_W'(1);

  logic portRead;
  assign portRead = ioRdEn && (ioAddr == INDEX_ADDR || ioAddr == DATA_ADDR);

  p_locked_reads_ff_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgActive && portRead) |-> (ioRdData == 8'hFF));

  p_unlock_after_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgActive) |-> $past(ioWrEn && ioAddr == INDEX_ADDR && ioWrData == 8'h55));

  p_exit_relocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgActive && ioWrEn && ioAddr == DATA_ADDR && curIndex == 8'h02 && ioWrData == 8'h02)
    |=> !cfgActive);

  p_base_frozen_locked_r8: assert property (@(posedge clk) disable iff (!rstN)
    !cfgActive |=> $stable(gpioBase));

  p_chip_id_hi_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgActive && ioRdEn && ioAddr == DATA_ADDR && curIndex == 8'h20)
    |-> (ioRdData == CHIP_ID[15:8]));

  p_idle_read_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !portRead |-> (ioRdData == 8'h00));

endmodule

bind sioCfgPort sioCfgPortChk #(
  .ADDR_W     (ADDR_W),
  .INDEX_ADDR (INDEX_ADDR),
  .CHIP_ID    (CHIP_ID)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .ioAddr    (ioAddr),
  .ioWrEn    (ioWrEn),
  .ioWrData  (ioWrData),
  .ioRdEn    (ioRdEn),
  .ioRdData  (ioRdData),
  .cfgActive (cfgActive),
  .gpioBase  (gpioBase),
  .curIndex  (curIndex)
);

// File: tb/sioCfgPort_tb_top.sv
`timescale 1ns/1ps
module sioCfgPort_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;
  localparam logic [15:0] IDX = 16'h002E;
  localparam logic [15:0] DAT = 16'h002F;
  localparam logic [15:0] EXP_ID = 16'h8728;
  localparam logic [3:0]  EXP_REV = 4'h6;
  localparam logic [31:0] KEY = 32'h87015555;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        ioWrEn = 1'b0;
  logic [7:0]  ioWrData = '0;
  logic        ioRdEn = 1'b0;
  logic [7:0]  ioRdData;
  logic        cfgActive;
  logic [15:0] gpioBase;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sioCfgPort #(
    .ADDR_W(16), .INDEX_ADDR(IDX), .CHIP_ID(EXP_ID), .CHIP_REV(EXP_REV), .GPIO_DEV(8'h07)
  ) dut_i (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioWrData(ioWrData),
    .ioRdEn(ioRdEn), .ioRdData(ioRdData), .cfgActive(cfgActive), .gpioBase(gpioBase)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic ioWr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic ioRd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioRdEn = 1'b1;
    #(CLK_PERIOD/4);
    d = ioRdData;
    ioRdEn = 1'b0;
  endtask

  // write and read the same port in one cycle; returns the read value
  task automatic ioWrRd(input logic [15:0] a, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWrEn = 1'b1; ioRdEn = 1'b1;
    #(CLK_PERIOD/4);
    r = ioRdData;
    @(negedge clk);
    ioWrEn = 1'b0; ioRdEn = 1'b0;
  endtask

  task automatic unlock();
    ioWr(IDX, 8'h87); ioWr(IDX, 8'h01); ioWr(IDX, 8'h55); ioWr(IDX, 8'h55);
  endtask

  task automatic relock();
    ioWr(IDX, 8'h02); ioWr(DAT, 8'h02);
  endtask

  task automatic regWr(input logic [7:0] i, input logic [7:0] v);
    ioWr(IDX, i); ioWr(DAT, v);
  endtask

  task automatic regRd(input logic [7:0] i, output logic [7:0] v);
    ioWr(IDX, i); ioRd(DAT, v);
  endtask

  function automatic logic [7:0] expReg(input logic [7:0] i, input logic [7:0] dev,
                                        input logic [15:0] base);
    case (i)
      8'h02: expReg = 8'h00;
      8'h07: expReg = dev;
      8'h20: expReg = EXP_ID[15:8];
      8'h21: expReg = EXP_ID[7:0];
      8'h22: expReg = {4'h0, EXP_REV};
      8'h62: expReg = (dev == 8'h07) ? base[15:8] : 8'hFF;
      8'h63: expReg = (dev == 8'h07) ? base[7:0]  : 8'hFF;
      default: expReg = 8'hFF;
    endcase
  endfunction

  initial begin : watchdog
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    logic [7:0] devM;
    logic [15:0] baseM;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(cfgActive == 1'b0, "R1 locked after reset", cfgActive, 0);
    check(gpioBase == 16'h0, "R1 base after reset", gpioBase, 0);
    // R10 idle read value
    #(CLK_PERIOD/4);
    check(ioRdData == 8'h00, "R10 idle read", ioRdData, 0);

    // R4 locked reads and ignored writes
    ioRd(IDX, r); check(r == 8'hFF, "R4 locked index read", r, 8'hFF);
    ioRd(DAT, r); check(r == 8'hFF, "R4 locked data read", r, 8'hFF);
    ioWr(IDX, 8'h07); ioWr(DAT, 8'h3C);
    ioWr(IDX, 8'h20);
    unlock();
    ioRd(IDX, r); check(r == 8'h00, "R4 index not loaded while locked", r, 0);
    regRd(8'h07, r); check(r == 8'h00, "R1/R4 selector zero", r, 0);
    relock();

    // R2 edge timing
    ioWr(IDX, 8'h87); ioWr(IDX, 8'h01); ioWr(IDX, 8'h55);
    check(cfgActive == 1'b0, "R2 not open after three bytes", cfgActive, 0);
    ioWr(IDX, 8'h55);
    check(cfgActive == 1'b1, "R2 open after fourth byte", cfgActive, 1);
    relock();
    check(cfgActive == 1'b0, "R5 relocked", cfgActive, 0);

    // R3 other addresses interleaved do not disturb the match
    ioWr(IDX, 8'h87); ioWr(16'h0080, 8'h00); ioRd(DAT, r); ioWr(IDX, 8'h01);
    ioWr(DAT, 8'h11); ioWr(IDX, 8'h55); ioWr(IDX, 8'h55);
    check(cfgActive == 1'b1, "R3 interleaved accesses", cfgActive, 1);
    relock();

    // R3 sweep: one wrong byte at each key position
    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 256; v++) begin
        logic [31:0] hist;
        bit hit;
        logic [7:0] kb;
        if (v == int'(KEY[31-8*p -: 8])) continue;
        hist = '0; hit = 1'b0;
        for (int k = 0; k < p; k++) begin
          kb = KEY[31-8*k -: 8];
          ioWr(IDX, kb); hist = {hist[23:0], kb}; hit |= (hist == KEY);
        end
        ioWr(IDX, 8'(v)); hist = {hist[23:0], 8'(v)}; hit |= (hist == KEY);
        for (int k = p; k < 4; k++) begin
          kb = KEY[31-8*k -: 8];
          ioWr(IDX, kb); hist = {hist[23:0], kb}; hit |= (hist == KEY);
        end
        check(cfgActive == hit, $sformatf("R3 wrong byte pos %0d val %0h", p, v), cfgActive, hit);
        if (cfgActive) relock();
        else ioWr(IDX, 8'h00);
      end
    end

    // R6/R7/R8 selector sweep
    unlock();
    devM = 8'h00; baseM = 16'h0000;
    for (int l = 0; l < 256; l++) begin
      logic [7:0] hv, lv;
      hv = 8'(l) ^ 8'h5A; lv = ~8'(l);
      regWr(8'h07, 8'(l)); devM = 8'(l);
      regWr(8'h62, hv); regWr(8'h63, lv);
      if (devM == 8'h07) baseM = {hv, lv};
      regRd(8'h07, r); check(r == devM, "R6 selector readback", r, devM);
      regRd(8'h62, r); check(r == expReg(8'h62, devM, baseM), "R8 base hi", r, expReg(8'h62, devM, baseM));
      regRd(8'h63, r); check(r == expReg(8'h63, devM, baseM), "R8 base lo", r, expReg(8'h63, devM, baseM));
      check(gpioBase == baseM, "R8 gpioBase port", gpioBase, baseM);
    end
    regWr(8'h20, 8'h00); regWr(8'h21, 8'h00); regWr(8'h22, 8'hF0);
    regRd(8'h20, r); check(r == EXP_ID[15:8], "R7 id hi read-only", r, EXP_ID[15:8]);
    regRd(8'h21, r); check(r == EXP_ID[7:0], "R7 id lo read-only", r, EXP_ID[7:0]);
    regRd(8'h22, r); check(r == {4'h0, EXP_REV}, "R7 revision", r, {4'h0, EXP_REV});

    // R9 full index sweep with GPIO selected
    regWr(8'h07, 8'h07); devM = 8'h07;
    regWr(8'h62, 8'hA5); regWr(8'h63, 8'hC3); baseM = 16'hA5C3;
    for (int i = 0; i < 256; i++) begin
      ioWr(IDX, 8'(i));
      ioRd(IDX, r); check(r == 8'(i), "R9 index readback", r, i);
      ioRd(DAT, r); check(r == expReg(8'(i), devM, baseM), "R9 register map read", r, expReg(8'(i), devM, baseM));
    end
    check(cfgActive == 1'b1, "R5 reads of 0x02 do not relock", cfgActive, 1);

    // R5 exit needs the exact code; state retained
    regWr(8'h02, 8'h01);
    check(cfgActive == 1'b1, "R5 wrong exit code ignored", cfgActive, 1);
    regWr(8'h02, 8'h02);
    check(cfgActive == 1'b0, "R5 exit code relocks", cfgActive, 0);
    ioRd(DAT, r); check(r == 8'hFF, "R4 read after relock", r, 8'hFF);
    unlock();
    regRd(8'h07, r); check(r == 8'h07, "R5 selector retained", r, 8'h07);
    check(gpioBase == 16'hA5C3, "R5 base retained", gpioBase, 16'hA5C3);

    // R10 same-cycle write and read
    ioWr(IDX, 8'h07);
    ioWrRd(DAT, 8'h11, r); check(r == 8'h07, "R10 read sees old selector", r, 8'h07);
    ioRd(DAT, r); check(r == 8'h11, "R10 new selector visible", r, 8'h11);
    ioWr(IDX, 8'h02);
    ioWrRd(DAT, 8'h02, r); check(r == 8'h00, "R10 exit cycle read pre-exit", r, 0);
    check(cfgActive == 1'b0, "R10 relocked after exit cycle", cfgActive, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule